// File: doc/BRIEF.md
# Multi-Lane Serial Memory Read Sequencer

This block is the main side of a serial-peripheral read transaction aimed at memories that return data over several lanes. On a start request it lowers chip select, shifts an 8-bit command out on lane 0 one bit per serial clock, and follows it with zero or more address bytes on the same lane. It then releases every lane output enable and runs a configurable number of idle turnaround clocks. After that it receives data with all lanes acting as inputs: two lanes per clock in dual mode, four in quad mode.

Each received byte is presented on a parallel byte output with a one-cycle valid strobe. The sequencer stops after the requested number of bytes, drives the serial clock low for one final half period, and raises chip select. The serial clock idles low. Outgoing bits change on falling edges, and incoming lanes are captured on rising edges. The serial clock half period is a whole number of system clocks.

Top module: `spi_multilane_reader`

## Requirements
- R1: Out of reset and while idle, csN is 1, sclk is 0, sioOe is 4'b0000, busy is 0 and rxValid is 0.
- R2: A start pulse while idle with nonzero byteCount lowers csN and raises busy. The command byte is then sent MSB first on sioOut[0], one bit per sclk period. sclk idles low, each bit changes on a falling edge (the first as csN falls) and is stable at the following rising edge. sioOe is exactly 4'b0001 during the whole single-lane phase.
- R3: After the command, the lowest addrBytes bytes of addr are sent on sioOut[0], most significant byte and bit first. addrBytes of 0 sends no address, and a value above ADDR_BYTES_MAX is treated as ADDR_BYTES_MAX.
- R4: sioOe falls to 4'b0000 on the falling edge that ends the last single-lane bit. DUMMY_CLKS sclk periods follow with no capture, so the first capturing rising edge comes at least one sclk period after release.
- R5: In dual mode (quadMode=0) each byte takes 4 sclk periods. At each rising edge sioIn[1] gives the higher bit and sioIn[0] the lower bit of a pair, so sioIn[1] carries bits 7,5,3,1 and sioIn[0] carries bits 6,4,2,0, with pair 7/6 first. sioIn[3:2] are ignored.
- R6: In quad mode (quadMode=1) each byte takes 2 sclk periods: sioIn[3:0] give bits 7..4 at the first rising edge and bits 3..0 at the second.
- R7: Every received byte appears on rxData with rxValid high for exactly one clk cycle while csN is low, and exactly byteCount bytes are delivered in reception order.
- R8: A transaction has exactly 8+8*n+DUMMY_CLKS+byteCount*(4 dual or 2 quad) sclk rising edges, where n is the effective address byte count. csN stays low without a break from the first command bit to the last data edge, then rises once, and busy falls with it.
- R9: A start pulse while busy has no effect on the running transaction. A start pulse with byteCount of 0 is ignored: csN stays high and no sclk edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read when idle |
| quadMode | input | 1 | 0 selects two data lanes, 1 selects four |
| cmdByte | input | 8 | Command byte sent on lane 0 |
| addr | input | 8*ADDR_BYTES_MAX | Address, right-aligned |
| addrBytes | input | clog2(ADDR_BYTES_MAX+1) | Number of address bytes to send |
| byteCount | input | CNT_W | Number of data bytes to receive |
| busy | output | 1 | A transaction is in progress |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low chip select |
| sioOut | output | 4 | Lane output values |
| sioOe | output | 4 | Lane output enables |
| sioIn | input | 4 | Lane input values |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | One-cycle strobe for rxData |

## Verification
The bench builds the block with HALF_DIV=3, DUMMY_CLKS=2, ADDR_BYTES_MAX=4 and CNT_W=8. With this odd half period, the lane capture point sits several system clocks away from the memory model's drive point. With a short turnaround, the count of sclk edges before the first captured beat stays small enough to check exactly. The four-byte address limit allows both the full address and a clamped oversize request. An 8-bit byte count keeps the one-byte and zero-byte boundary runs cheap.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TX,
    SQ_TURN,
    SQ_RX,
    SQ_TRAIL
  } seqState_t;

  // strobes from the control to the datapath, one clk cycle each
  typedef struct packed {
    logic load;       // capture command and address, enable lane 0
    logic shiftTx;    // advance to next outgoing bit (falling sclk)
    logic releaseOe;  // drop all lane enables (falling sclk)
    logic sample;     // capture lanes (rising sclk)
    logic lastBeat;   // this capture completes a byte
    logic quad;       // four-lane capture width
  } dpStrobe_t;

endpackage

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
#(
  parameter int HALF_DIV       = 4,
  parameter int DUMMY_CLKS     = 8,
  parameter int ADDR_BYTES_MAX = 4,
  parameter int CNT_W          = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic                               quadMode,
  input  logic [$clog2(ADDR_BYTES_MAX+1)-1:0] addrBytes,
  input  logic [CNT_W-1:0]                   byteCount,
  output logic [$clog2(ADDR_BYTES_MAX+1)-1:0] nAddr,
  output dpStrobe_t                          strobe,
  output logic                               sclk,
  output logic                               csN,
  output logic                               busy
);

  localparam int ABYTE_W  = $clog2(ADDR_BYTES_MAX + 1);
  localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int TX_MAX   = 8 + 8 * ADDR_BYTES_MAX;
  localparam int BIT_W    = $clog2(TX_MAX + 1);
  localparam int DUMMY_W  = (DUMMY_CLKS > 1) ? $clog2(DUMMY_CLKS) : 1;

  seqState_t          st;
  logic [DIV_W-1:0]   divCnt;
  logic               sclkQ;
  logic               csNQ;
  logic               quadQ;
  logic [BIT_W-1:0]   bitCnt;
  logic [DUMMY_W-1:0] dummyCnt;
  logic [1:0]         beatCnt;
  logic [CNT_W-1:0]   bytesLeft;

  logic             tick;
  logic             accept;
  logic             rise;
  logic             fall;
  logic [BIT_W-1:0] txBitsLast;

  // clamp the requested address length
  always_comb begin
    if (addrBytes > ABYTE_W'(ADDR_BYTES_MAX)) nAddr = ABYTE_W'(ADDR_BYTES_MAX);
    else                                      nAddr = addrBytes;
  end

  assign txBitsLast = BIT_W'(8) + (BIT_W'(nAddr) << 3) - BIT_W'(1);
  assign tick   = (divCnt == DIV_W'(HALF_DIV - 1));
  assign accept = (st == SQ_IDLE) && start && (byteCount != '0);
  assign rise   = tick && !sclkQ && (st == SQ_TX || st == SQ_TURN || st == SQ_RX);
  assign fall   = tick && sclkQ;

  always_comb begin
    strobe           = '0;
    strobe.load      = accept;
    strobe.shiftTx   = fall && (st == SQ_TX) && (bitCnt != '0);
    strobe.releaseOe = fall && (st == SQ_TX) && (bitCnt == '0);
    strobe.sample    = rise && (st == SQ_RX);
    strobe.lastBeat  = rise && (st == SQ_RX) && (beatCnt == 2'd0);
    strobe.quad      = quadQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= SQ_IDLE;
      divCnt    <= '0;
      sclkQ     <= 1'b0;
      csNQ      <= 1'b1;
      quadQ     <= 1'b0;
      bitCnt    <= '0;
      dummyCnt  <= '0;
      beatCnt   <= '0;
      bytesLeft <= '0;
    end else if (st == SQ_IDLE) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
      if (accept) begin
        st        <= SQ_TX;
        csNQ      <= 1'b0;
        quadQ     <= quadMode;
        bitCnt    <= txBitsLast;
        bytesLeft <= byteCount;
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (st == SQ_TRAIL) begin
        if (tick) begin
          st   <= SQ_IDLE;
          csNQ <= 1'b1;
        end
      end else begin
        if (tick) sclkQ <= !sclkQ;
        if (fall) begin
          unique case (st)
            SQ_TX: begin
              if (bitCnt == '0) begin
                st       <= SQ_TURN;
                dummyCnt <= DUMMY_W'(DUMMY_CLKS - 1);
              end else begin
                bitCnt <= bitCnt - BIT_W'(1);
              end
            end
            SQ_TURN: begin
              if (dummyCnt == '0) begin
                st      <= SQ_RX;
                beatCnt <= quadQ ? 2'd1 : 2'd3;
              end else begin
                dummyCnt <= dummyCnt - DUMMY_W'(1);
              end
            end
            SQ_RX: begin
              if (beatCnt == 2'd0) begin
                if (bytesLeft == CNT_W'(1)) begin
                  st <= SQ_TRAIL;
                end else begin
                  bytesLeft <= bytesLeft - CNT_W'(1);
                  beatCnt   <= quadQ ? 2'd1 : 2'd3;
                end
              end else begin
                beatCnt <= beatCnt - 2'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sclk = sclkQ;
  assign csN  = csNQ;
  assign busy = (st != SQ_IDLE);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN) csNQ |-> !sclkQ); // R2
  AST_BUSY_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(quadQ)); // R9

endmodule

// File: rtl/spiq_datapath.sv
module spiq_datapath
  import spiq_pkg::*;
#(
  parameter int ADDR_BYTES_MAX = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  dpStrobe_t                           strobe,
  input  logic [7:0]                          cmdByte,
  input  logic [8*ADDR_BYTES_MAX-1:0]         addr,
  input  logic [$clog2(ADDR_BYTES_MAX+1)-1:0] nAddr,
  input  logic [3:0]                          sioIn,
  output logic [3:0]                          sioOut,
  output logic [3:0]                          sioOe,
  output logic [7:0]                          rxData,
  output logic                                rxValid
);

  localparam int ABYTE_W = $clog2(ADDR_BYTES_MAX + 1);
  localparam int ADDR_W  = 8 * ADDR_BYTES_MAX;
  localparam int SR_W    = 8 + ADDR_W;

  logic [SR_W-1:0]      txSr;
  logic                 oeQ;
  logic [7:0]           rxSr;
  logic [7:0]           rxNext;
  logic [ABYTE_W+2:0]   alignShift;
  logic [ADDR_W-1:0]    addrAligned;

  // left-align the used address bytes right behind the command
  assign alignShift  = {ABYTE_W'(ADDR_BYTES_MAX) - nAddr, 3'b000};
  assign addrAligned = addr << alignShift;

  always_comb begin
    if (strobe.quad) rxNext = {rxSr[3:0], sioIn[3:0]};
    else             rxNext = {rxSr[5:0], sioIn[1], sioIn[0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr    <= '0;
      oeQ     <= 1'b0;
      rxSr    <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.load) begin
        txSr <= {cmdByte, addrAligned};
        oeQ  <= 1'b1;
      end else if (strobe.shiftTx) begin
        txSr <= txSr << 1;
      end
      if (strobe.releaseOe) oeQ <= 1'b0;
      if (strobe.sample) begin
        rxSr <= rxNext;
        if (strobe.lastBeat) begin
          rxData  <= rxNext;
          rxValid <= 1'b1;
        end
      end
    end
  end

  assign sioOut = {3'b000, txSr[SR_W-1]};
  assign sioOe  = {3'b000, oeQ};

  AST_SINGLE_LANE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (sioOe == 4'b0000) || (sioOe == 4'b0001)); // R2
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |-> (sioOe == 4'b0000)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R7

endmodule

// File: rtl/spi_multilane_reader.sv
module spi_multilane_reader
  import spiq_pkg::*;
#(
  parameter int HALF_DIV       = 4,
  parameter int DUMMY_CLKS     = 8,
  parameter int ADDR_BYTES_MAX = 4,
  parameter int CNT_W          = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                start,
  input  logic                                quadMode,
  input  logic [7:0]                          cmdByte,
  input  logic [8*ADDR_BYTES_MAX-1:0]         addr,
  input  logic [$clog2(ADDR_BYTES_MAX+1)-1:0] addrBytes,
  input  logic [CNT_W-1:0]                    byteCount,
  output logic                                busy,
  output logic                                sclk,
  output logic                                csN,
  output logic [3:0]                          sioOut,
  output logic [3:0]                          sioOe,
  input  logic [3:0]                          sioIn,
  output logic [7:0]                          rxData,
  output logic                                rxValid
);

  localparam int ABYTE_W = $clog2(ADDR_BYTES_MAX + 1);

  dpStrobe_t          strobe;
  logic [ABYTE_W-1:0] nAddr;

  spiq_ctrl #(
    .HALF_DIV(HALF_DIV),
    .DUMMY_CLKS(DUMMY_CLKS),
    .ADDR_BYTES_MAX(ADDR_BYTES_MAX),
    .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .start(start),
    .quadMode(quadMode),
    .addrBytes(addrBytes),
    .byteCount(byteCount),
    .nAddr(nAddr),
    .strobe(strobe),
    .sclk(sclk),
    .csN(csN),
    .busy(busy)
  );

  spiq_datapath #(
    .ADDR_BYTES_MAX(ADDR_BYTES_MAX)
  ) i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .cmdByte(cmdByte),
    .addr(addr),
    .nAddr(nAddr),
    .sioIn(sioIn),
    .sioOut(sioOut),
    .sioOe(sioOe),
    .rxData(rxData),
    .rxValid(rxValid)
  );

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sioOe == 4'b0000)); // R1
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !csN); // R7

endmodule

// File: tb/test_spi_multilane_reader.sv
module test_spi_multilane_reader;

  localparam int HD = 3;
  localparam int DC = 2;
  localparam int AM = 4;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        quadMode = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic [31:0] addr = '0;
  logic [2:0]  addrBytes = '0;
  logic [CW-1:0] byteCount = '0;
  logic        busy, sclk, csN, rxValid;
  logic [3:0]  sioOut, sioOe;
  logic [3:0]  sioIn = 4'b0000;
  logic [7:0]  rxData;

  spi_multilane_reader #(
    .HALF_DIV(HD), .DUMMY_CLKS(DC), .ADDR_BYTES_MAX(AM), .CNT_W(CW)
  ) i_spi_multilane_reader (
    .clk(clk), .rstN(rstN), .start(start), .quadMode(quadMode),
    .cmdByte(cmdByte), .addr(addr), .addrBytes(addrBytes),
    .byteCount(byteCount), .busy(busy), .sclk(sclk), .csN(csN),
    .sioOut(sioOut), .sioOe(sioOe), .sioIn(sioIn),
    .rxData(rxData), .rxValid(rxValid)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // memory model state
  bit          cfgQuad = 0;
  int          expTxBits = 0;
  logic [7:0]  seedB = 8'h00;
  int          risingCnt = 0;
  logic [39:0] capTx = '0;
  int          oeBad = 0;
  int          rxCnt = 0;
  logic [7:0]  rxBuf [0:31];
  int          csRise = 0;
  int          csFall = 0;

  function automatic logic [7:0] patByte(int j);
    return seedB ^ 8'((j * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge sclk) begin
    if (risingCnt < expTxBits) begin
      capTx = {capTx[38:0], sioOut[0]};
      if (sioOe !== 4'b0001) oeBad++;
    end else begin
      if (sioOe !== 4'b0000) oeBad++;
    end
    risingCnt++;
  end

  always @(negedge sclk) begin
    int idx;
    logic [7:0] b;
    idx = risingCnt - expTxBits - DC;
    if (idx < 0) begin
      sioIn = 4'b1010;
    end else if (cfgQuad) begin
      b = patByte(idx / 2);
      sioIn = (idx % 2 == 0) ? b[7:4] : b[3:0];
    end else begin
      b = patByte(idx / 4);
      // lanes 3:2 carry junk in dual mode (R5)
      sioIn = {idx[0], ~idx[0], b[7 - 2 * (idx % 4)], b[6 - 2 * (idx % 4)]};
    end
  end

  always @(posedge csN) csRise++;
  always @(negedge csN) csFall++;

  always @(negedge clk) begin
    if (rxValid === 1'b1) begin
      rxBuf[rxCnt % 32] = rxData;
      rxCnt++;
    end
  end

  task automatic clearMon();
    risingCnt = 0; capTx = '0; oeBad = 0; rxCnt = 0; csRise = 0; csFall = 0;
    sioIn = 4'b1010;
  endtask

  task automatic waitIdle(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) begin ok = 1; break; end
    end
  endtask

  task automatic doRead(input bit q, input logic [7:0] cmd, input logic [31:0] a,
                        input int nA, input int nEff, input int cnt,
                        input logic [7:0] seed, input bit midStart);
    logic [39:0] expTx;
    bit ok;
    int expRise;
    clearMon();
    cfgQuad = q; seedB = seed; expTxBits = 8 + 8 * nEff;
    @(negedge clk);
    quadMode = q; cmdByte = cmd; addr = a; addrBytes = 3'(nA); byteCount = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && csN === 1'b0, "R2 busy and csN after start", {busy, csN}, 2'b10);
    if (midStart) begin
      repeat (25) @(negedge clk);
      cmdByte = ~cmd; byteCount = CW'(cnt + 3); quadMode = ~q; addrBytes = 3'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitIdle(ok);
    chk(ok, "R8 transaction completes", ok, 1);
    expTx = 40'(cmd);
    for (int i = nEff - 1; i >= 0; i--) expTx = (expTx << 8) | 40'(a[8*i +: 8]);
    chk(capTx == expTx, "R2/R3 command and address bits on lane 0", capTx, expTx);
    chk(oeBad == 0, "R2/R4 lane enables per phase", oeBad, 0);
    chk(rxCnt == cnt, "R7 number of received bytes", rxCnt, cnt);
    for (int j = 0; j < cnt && j < 32; j++)
      chk(rxBuf[j] == patByte(j), q ? "R6 quad byte value" : "R5 dual byte value",
          rxBuf[j], patByte(j));
    expRise = expTxBits + DC + cnt * (q ? 2 : 4);
    chk(risingCnt == expRise, "R8 sclk rising edge count", risingCnt, expRise);
    chk(csRise == 1 && csFall == 1, "R8 single unbroken chip select frame",
        csRise * 16 + csFall, 17);
    chk(csN === 1'b1 && sclk === 1'b0, "R8 idle after read", {csN, sclk}, 2'b10);
    if (midStart)
      chk(rxCnt == cnt && csRise == 1, "R9 start while busy ignored", rxCnt, cnt);
  endtask

  task automatic testReset();
    chk(csN === 1'b1, "R1 csN high in reset", csN, 1);
    chk(sclk === 1'b0, "R1 sclk low in reset", sclk, 0);
    chk(sioOe === 4'b0000, "R1 lane enables off", sioOe, 0);
    chk(busy === 1'b0 && rxValid === 1'b0, "R1 busy and rxValid low", {busy, rxValid}, 0);
  endtask

  task automatic testZeroCount();
    clearMon();
    expTxBits = 8;
    @(negedge clk);
    byteCount = '0; addrBytes = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && csN === 1'b1 && csFall == 0, "R9 zero byte count ignored",
        {busy, csN}, 2'b01);
    chk(risingCnt == 0, "R9 no sclk edge for zero count", risingCnt, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    doRead(1'b0, 8'h3B, 32'h0012_3456, 3, 3, 5, 8'h5A, 1'b0);   // dual, 3 address bytes
    doRead(1'b1, 8'h6B, 32'hA1B2_C3D4, 4, 4, 4, 8'hC3, 1'b0);   // quad, full address
    doRead(1'b1, 8'hEB, 32'hFFFF_FFFF, 0, 0, 1, 8'h0F, 1'b0);   // quad, no address, 1 byte
    doRead(1'b0, 8'h81, 32'h0102_0304, 7, 4, 2, 8'h96, 1'b0);   // R3 clamp of oversize length
    doRead(1'b0, 8'h3C, 32'h0000_77AA, 2, 2, 3, 8'h21, 1'b1);   // R9 start while busy
    testZeroCount();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R8 run did not finish actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule